// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is a synthesizable memory-side model of one SDRAM data path. Registered commands select a bank and a column in a small internal array. The block then runs a column burst of 1, 2, 4 or 8 beats. It takes write data from the DQ input, or drives read data on the DQ output after a fixed latency.

The clock-enable input is sampled on every rising edge. The internal enable that advances all command, burst and data logic is that sample taken one edge later. While a burst is running, a low sample freezes the next internal edge. On a frozen edge every counter holds, pin inputs are discarded, and read data stays driven. When no bank is open and nothing is in flight, a low sample puts the block into power-down instead. A high sample ends either state, and operation resumes on the edge that follows.

The DQ path has no handshake and no back-pressure. The host must present one write beat on every non-frozen edge of a write burst. It must accept one read beat on every edge where `dq_oe` is high. `dq_oe` serves as the valid flag of the read stream, and the host throttles both directions only through `cke`.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset, `mode` is IDLE (0), `dq_oe` is 0 and `dq_out` is 0. All banks are closed and every array word is zero.
- R2: The internal enable equals `cke` as sampled on the previous rising edge. An edge that samples `cke` low still advances the logic itself, but the next edge does not. From that edge until the next high sample, `mode` reads SUSPENDED (2) whenever the block is not in power-down.
- R3: On a frozen edge, the command, bank, column, mask and write data inputs have no effect. For example, a READ presented on a frozen edge never produces `dq_oe`, and write data presented on it is never stored.
- R4: While the enable is low, `dq_out` and `dq_oe` keep their values, so a read beat already on the bus stays driven.
- R5: The burst beat counter does not advance on frozen edges. After a freeze, the burst resumes at the column where it stopped.
- R6: A high sample of `cke` ends the freeze, and the very next edge advances the burst again.
- R7: A low `cke` sample taken while no bank is open and no burst or read data is pending enters power-down, and `mode` reads POWER_DOWN (3). Commands given while `cke` stays low are discarded. The high sample that ends power-down returns `mode` to IDLE.
- R8: `bl_sel` gives the burst length 2^`bl_sel` (0→1, 1→2, 2→4, 3→8) and is captured with the READ or WRITE. Beat k addresses column (start & ~(L-1)) | ((start+k) & (L-1)), which wraps inside the aligned block of L columns.
- R9: A WRITE stores beat 0 from `dq_in` on the command edge and one further beat on each later non-frozen edge. A beat presented with `dm` high is not stored.
- R10: The first beat of a READ appears on `dq_out` with `dq_oe` high after the second non-frozen edge following the READ edge. Later beats follow on consecutive non-frozen edges, and `dq_oe` drops after the last beat.
- R11: The `cmd` encoding is 0 NOP, 1 ACTIVE (opens `bank`), 2 READ, 3 WRITE, 4 PRECHARGE (closes `bank`), and other values act as NOP. READ and WRITE to a closed bank are ignored. A new READ or WRITE ends any burst in progress, so at most one burst direction is active.
- R12: `mode` is ACTIVE_BURST (1) while a burst runs or read data is in flight and `cke` was sampled high, and IDLE (0) otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable, sampled every rising edge |
| cmd | input | 3 | Command code (R11) |
| bank | input | $clog2(NB) | Bank address |
| col | input | COL_W | Start column address |
| bl_sel | input | 2 | Burst length select (R8) |
| dm | input | 1 | Write data mask for the current beat |
| dq_in | input | W | Write data |
| dq_out | output | W | Read data |
| dq_oe | output | 1 | Read data valid / output enable |
| mode | output | 2 | 0 IDLE, 1 ACTIVE_BURST, 2 SUSPENDED, 3 POWER_DOWN |

## Verification
The bench places a low `cke` sample in the middle of both a write burst and a read burst. A design that freezes the sampling edge itself, instead of the edge after it, shows the read beats shifted by one. A design whose counter keeps moving stores the late write beats at the wrong columns. A READ with junk data is placed on the frozen edge; if pins leak through, the design starts an unrequested read or stores the junk word. Wrapping bursts of lengths 2 and 8, a masked beat, a READ to a closed bank and commands given during power-down catch address arithmetic faults, a misdecoded bank state and power-down that fails to gate command capture.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_BURST = 2'd1,
    MODE_SUSP  = 2'd2,
    MODE_PDN   = 2'd3
  } mode_e;
endpackage

// File: rtl/sdr_cke_ctrl.sv
module sdr_cke_ctrl
  import sdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cke,
  input  logic  quiet,
  input  logic  busy,
  output logic  en,
  output mode_e mode
);
  logic cke_q;
  logic pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q <= 1'b1;
      pd_q  <= 1'b0;
    end else begin
      cke_q <= cke;
      pd_q  <= !cke && (pd_q || quiet);
    end
  end

  assign en = cke_q;

  always_comb begin
    if (pd_q)       mode = MODE_PDN;
    else if (!cke_q) mode = MODE_SUSP;
    else if (busy)  mode = MODE_BURST;
    else            mode = MODE_IDLE;
  end

  // R7: power-down always implies a frozen internal enable
  assert_pdn_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> !cke_q);

  // R7: power-down is only entered from a quiet state
  assert_pdn_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(quiet));
endmodule

// File: rtl/sdr_store.sv
module sdr_store #(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
  import sdr_pkg::*;
#(
  parameter int NB         = 4,
  parameter int COL_W      = 4,
  parameter int BL_LOG_MAX = 3,
  localparam int BA_W      = $clog2(NB),
  localparam int AW        = BA_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  bank,
  input  logic [COL_W-1:0] col,
  input  logic [1:0]       bl_sel,
  input  logic             dm,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             rd_act,
  output logic [AW-1:0]    rd_addr,
  output logic             burst_on,
  output logic             any_open
);
  localparam int CW = (BL_LOG_MAX < 1) ? 1 : BL_LOG_MAX;

  logic [NB-1:0]    open_q;
  logic             wr_act;
  logic [CW-1:0]    cnt;
  logic [BA_W-1:0]  base_bank;
  logic [COL_W-1:0] base_col;
  logic [1:0]       bl_log;
  logic [1:0]       bl_new;
  logic [CW-1:0]    bl_last;
  logic [COL_W-1:0] colmask;
  logic [COL_W-1:0] cur_col;
  logic             go_rd;
  logic             go_wr;

  assign bl_new  = (int'(bl_sel) > BL_LOG_MAX) ? 2'(BL_LOG_MAX) : bl_sel;
  assign bl_last = CW'((1 << bl_log) - 1);
  assign colmask = COL_W'((1 << bl_log) - 1);
  assign cur_col = (base_col & ~colmask) | ((base_col + COL_W'(cnt)) & colmask);

  assign go_rd = en && (cmd == CMD_RD) && open_q[bank];
  assign go_wr = en && (cmd == CMD_WR) && open_q[bank];

  assign wr_en   = en && !dm && (go_wr || (wr_act && !go_rd));
  assign wr_addr = go_wr ? {bank, col} : {base_bank, cur_col};
  assign rd_addr = {base_bank, cur_col};
  assign burst_on = rd_act || wr_act;
  assign any_open = |open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= '0;
      rd_act    <= 1'b0;
      wr_act    <= 1'b0;
      cnt       <= '0;
      base_bank <= '0;
      base_col  <= '0;
      bl_log    <= '0;
    end else if (en) begin
      if (cmd == CMD_ACT) open_q[bank] <= 1'b1;
      if (cmd == CMD_PRE) open_q[bank] <= 1'b0;
      if (go_rd) begin
        rd_act    <= 1'b1;
        wr_act    <= 1'b0;
        cnt       <= '0;
        base_bank <= bank;
        base_col  <= col;
        bl_log    <= bl_new;
      end else if (go_wr) begin
        rd_act    <= 1'b0;
        wr_act    <= (bl_new != 2'd0);
        cnt       <= CW'(1);
        base_bank <= bank;
        base_col  <= col;
        bl_log    <= bl_new;
      end else if (rd_act || wr_act) begin
        if (cnt == bl_last) begin
          rd_act <= 1'b0;
          wr_act <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: a frozen edge changes no burst or bank state
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt) && $stable(rd_act) && $stable(wr_act) && $stable(open_q));

  // R11: never a read and a write burst at once
  assert_single_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_act, wr_act}));

  // R8: the beat counter stays inside the selected length
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act || wr_act) |-> (cnt <= bl_last));
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdr_pkg::*;
#(
  parameter int W          = 16,
  parameter int NB         = 4,
  parameter int COL_W      = 4,
  parameter int BL_LOG_MAX = 3,
  localparam int BA_W      = $clog2(NB),
  localparam int AW        = BA_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic [2:0]       cmd,
  input  logic [BA_W-1:0]  bank,
  input  logic [COL_W-1:0] col,
  input  logic [1:0]       bl_sel,
  input  logic             dm,
  input  logic [W-1:0]     dq_in,
  output logic [W-1:0]     dq_out,
  output logic             dq_oe,
  output logic [1:0]       mode
);
  logic          en;
  mode_e         mode_w;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          rd_act;
  logic [AW-1:0] rd_addr;
  logic          burst_on;
  logic          any_open;
  logic [W-1:0]  rdata;
  logic          s1_v;
  logic [W-1:0]  s1_d;
  logic          busy;
  logic          quiet;

  assign busy  = burst_on || s1_v || dq_oe;
  assign quiet = !any_open && !busy;
  assign mode  = mode_w;

  sdr_cke_ctrl i_cke (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .quiet (quiet),
    .busy  (busy),
    .en    (en),
    .mode  (mode_w)
  );

  sdr_burst_ctrl #(
    .NB         (NB),
    .COL_W      (COL_W),
    .BL_LOG_MAX (BL_LOG_MAX)
  ) i_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cmd      (cmd_e'(cmd)),
    .bank     (bank),
    .col      (col),
    .bl_sel   (bl_sel),
    .dm       (dm),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_act   (rd_act),
    .rd_addr  (rd_addr),
    .burst_on (burst_on),
    .any_open (any_open)
  );

  sdr_store #(.AW(AW), .W(W)) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (dq_in),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  // two enabled stages give the read latency of R10
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_d   <= '0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else if (en) begin
      s1_v  <= rd_act;
      s1_d  <= rdata;
      dq_oe <= s1_v;
      if (s1_v) dq_out <= s1_d;
    end
  end

  // R4: read data and its valid flag hold across a frozen edge
  assert_dq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dq_out) && $stable(dq_oe));
endmodule

// File: tb/test_sdram_burst_engine.sv
`timescale 1ns/1ps
module test_sdram_burst_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  bank = 2'd0;
  logic [3:0]  col = 4'd0;
  logic [1:0]  bl_sel = 2'd0;
  logic        dm = 1'b0;
  logic [15:0] dq_in = 16'd0;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [1:0]  mode;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] ref_m [64];

  always #2.5 clk = ~clk;

  sdram_burst_engine i_sdram_burst_engine (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
    .bl_sel(bl_sel), .dm(dm), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .mode(mode)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int cidx(input int bk, input int c0, input int k, input int bls);
    int len = 1 << bls;
    return bk * 16 + ((c0 & ~(len - 1)) | ((c0 + k) & (len - 1)));
  endfunction

  task automatic put_cmd(input logic [2:0] c, input int bk, input int cl, input int bls);
    cmd = c; bank = 2'(bk); col = 4'(cl); bl_sel = 2'(bls);
  endtask

  // R11: ACTIVE opens a bank, PRECHARGE closes it
  task automatic open_bank(input int bk);
    put_cmd(3'd1, bk, 0, 0); step(); put_cmd(3'd0, 0, 0, 0);
  endtask

  task automatic close_bank(input int bk);
    put_cmd(3'd4, bk, 0, 0); step(); put_cmd(3'd0, 0, 0, 0);
  endtask

  // R9: write burst with no suspension, mask bit per beat
  task automatic wr_burst(input int bk, input int c0, input int bls,
                          input logic [15:0] base, input logic [7:0] msk);
    for (int k = 0; k < (1 << bls); k++) begin
      if (k == 0) put_cmd(3'd3, bk, c0, bls); else put_cmd(3'd0, 0, 0, 0);
      dq_in = base + 16'(k);
      dm = msk[k];
      step();
      if (!msk[k]) ref_m[cidx(bk, c0, k, bls)] = base + 16'(k);
    end
    put_cmd(3'd0, 0, 0, 0); dm = 1'b0; dq_in = 16'h0;
  endtask

  // R10 latency and R8 ordering checked on a plain read
  task automatic rd_check(input int bk, input int c0, input int bls, input string req);
    put_cmd(3'd2, bk, c0, bls); step();
    put_cmd(3'd0, 0, 0, 0);
    chk({req, " R10 oe after READ edge"}, dq_oe, 0);
    step();
    chk({req, " R10 oe after 1st edge"}, dq_oe, 0);
    for (int k = 0; k < (1 << bls); k++) begin
      step();
      chk({req, " R10 oe during beat"}, dq_oe, 1);
      chk({req, " R8 beat data"}, dq_out, ref_m[cidx(bk, c0, k, bls)]);
    end
    step();
    chk({req, " R10 oe after last beat"}, dq_oe, 0);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 dq_out", dq_out, 0);
  endtask

  task automatic t_basic_write();
    open_bank(1);
    put_cmd(3'd3, 1, 3, 1); dq_in = 16'hA100; step();
    chk("R12 mode during write burst", mode, 1);
    ref_m[cidx(1, 3, 0, 1)] = 16'hA100;
    put_cmd(3'd0, 0, 0, 0); dq_in = 16'hA101; step();
    ref_m[cidx(1, 3, 1, 1)] = 16'hA101;
    step();
    chk("R12 mode back to idle", mode, 0);
    rd_check(1, 3, 1, "R8 BL2 wrap");
  endtask

  task automatic t_write_suspend();
    open_bank(2);
    put_cmd(3'd3, 2, 8, 2); dq_in = 16'hB000; step();
    put_cmd(3'd0, 0, 0, 0); dq_in = 16'hB001; cke = 1'b0; step();
    chk("R2 mode suspended", mode, 2);
    // junk on the frozen edge (R3)
    put_cmd(3'd2, 2, 0, 0); dq_in = 16'hDEAD; cke = 1'b1; step();
    put_cmd(3'd0, 0, 0, 0); dq_in = 16'hB002; step();
    chk("R3 junk read ignored a", dq_oe, 0);
    dq_in = 16'hB003; step();
    chk("R3 junk read ignored b", dq_oe, 0);
    dq_in = 16'h0; step();
    chk("R3 junk read ignored c", dq_oe, 0);
    for (int k = 0; k < 4; k++) ref_m[cidx(2, 8, k, 2)] = 16'hB000 + 16'(k);
    rd_check(2, 8, 2, "R5 write resumed at column");
    rd_check(2, 0, 0, "R3 junk data not stored");
  endtask

  task automatic t_read_suspend();
    put_cmd(3'd2, 2, 8, 2); step();
    put_cmd(3'd0, 0, 0, 0); step();
    step();
    chk("R10 first beat", dq_out, ref_m[cidx(2, 8, 0, 2)]);
    cke = 1'b0; step();
    chk("R2 sampling edge still advances", dq_out, ref_m[cidx(2, 8, 1, 2)]);
    chk("R2 mode suspended in read", mode, 2);
    cke = 1'b1; step();
    chk("R4 dq held", dq_out, ref_m[cidx(2, 8, 1, 2)]);
    chk("R4 oe held", dq_oe, 1);
    step();
    chk("R6 resume next beat", dq_out, ref_m[cidx(2, 8, 2, 2)]);
    step();
    chk("R6 last beat", dq_out, ref_m[cidx(2, 8, 3, 2)]);
    step();
    chk("R10 oe drops", dq_oe, 0);
  endtask

  task automatic t_mask();
    wr_burst(1, 4, 2, 16'hC000, 8'b0000_0100);
    rd_check(1, 4, 2, "R9 masked beat");
  endtask

  task automatic t_bl8();
    wr_burst(1, 13, 3, 16'hE000, 8'h00);
    rd_check(1, 13, 3, "R8 BL8 wrap");
    rd_check(1, 9, 0, "R8 BL1");
  endtask

  task automatic t_closed_bank();
    put_cmd(3'd2, 3, 0, 2); step();
    put_cmd(3'd0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R11 read to closed bank", dq_oe, 0);
    end
  endtask

  task automatic t_power_down();
    close_bank(1);
    close_bank(2);
    cke = 1'b0; step();
    chk("R7 mode power-down", mode, 3);
    put_cmd(3'd1, 0, 0, 0); step();
    put_cmd(3'd3, 0, 0, 0); dq_in = 16'hF00D; step();
    chk("R7 still power-down", mode, 3);
    put_cmd(3'd0, 0, 0, 0); dq_in = 16'h0; cke = 1'b1; step();
    chk("R7 exit to idle", mode, 0);
    put_cmd(3'd2, 0, 0, 0); step();
    put_cmd(3'd0, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 activate in power-down discarded", dq_oe, 0);
    end
    open_bank(0);
    rd_check(0, 0, 0, "R7 write in power-down discarded");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_m[i] = 16'h0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic_write();
    t_write_suspend();
    t_read_suspend();
    t_mask();
    t_bl8();
    t_closed_bank();
    t_power_down();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #100000;
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule